// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns a single READ or WRITE command into the column addresses of one memory burst, one address per clock. A mode word, captured on a load strobe, sets the burst length, the ordering of beats (sequential or XOR-interleaved), the read latency and whether writes are forced to a single beat. For bursts of 2, 4 or 8 the beats stay inside the aligned block that holds the starting column. A full-page burst walks the whole column range from any start and wraps at the top until it is stopped.

Alongside the addresses the block drives a data-valid strobe. It is high once per beat. For writes it lines up with the address beat. For reads it is shifted by the latency captured with the command. A new command cuts off the burst in flight, and a stop input ends any burst.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid` and `data_valid` are low. The mode holds length 1, sequential order, latency 2 and single-write off.
- R2: `mode_load` captures `mode_word`. Bits [2:0] set the length: 000→1, 001→2, 011→8, 010→4, 111→full page, and every other code→1. Bit 3 set to 1 selects interleaved order. Bits [8:4] hold the latency: 2 or 3 is used as given, any other value gives 2. Bit 9 set to 1 forces single-beat writes. A command in the same cycle as the load still uses the previous mode.
- R3: A command registered at edge n puts beat k on `col_addr` with `col_valid` high in the cycle after edge n+k, one beat per clock. `col_valid` is low whenever no burst is running.
- R4: In sequential order with length L in {2,4,8}, the low log2(L) bits of beat k equal (start+k) mod L. The upper bits stay equal to the start column's upper bits.
- R5: In interleaved order with length L in {2,4,8}, the low log2(L) bits of beat k equal the start's low bits XOR k. The upper bits stay fixed.
- R6: A full-page burst gives start+k modulo 2^COL_W on beat k and runs until stopped. Bit 3 has no effect on a full-page burst.
- R7: `burst_stop` high at an edge with no command present ends the running burst. No beat appears after that edge.
- R8: A READ or WRITE during a burst abandons it. The new burst's beat 0 appears in the next cycle.
- R9: For a read registered at edge n with latency m, `data_valid` for beat k is high in the cycle that ends with edge n+m+k.
- R10: For a write, `data_valid` is high in exactly the cycles in which that write's address beats are valid, and `col_is_write` is high with them.
- R11: With bit 9 set, every write is one beat, including in full-page mode. Reads still use the programmed length.
- R12: If `cmd_rd` and `cmd_wr` are both high, the command is taken as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Capture `mode_word` at this edge |
| mode_word | input | 10 | Mode fields (length, order, latency, single-write) |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| start_col | input | COL_W | Starting column of the command |
| burst_stop | input | 1 | Terminate the running burst |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | An address beat is present |
| col_is_write | output | 1 | The current beat belongs to a write |
| data_valid | output | 1 | Data strobe, one cycle per beat |

## Verification
A wrong beat index or a wrong stored start column shows as a wrong `col_addr` in the very next beat. The error repeats on every later beat of that burst. A wrong length or a wrong end-of-burst decision shows as `col_valid` staying high, or dropping, one cycle off from the expected edge. A wrong latency capture or pipeline tap moves `data_valid` by a whole cycle. This appears up to three cycles after the beat that caused it, so the strobe is compared on every clock and not only while a burst runs.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   localparam int MODE_W = 10;

   typedef struct packed {
      logic       full_page;
      logic [2:0] len_m1;     // beats minus one, also the low-bit wrap mask
      logic       interleave;
      logic [2:0] lat;
      logic       wr_single;
   } mode_t;

   function automatic mode_t decode_mode(input logic [MODE_W-1:0] w,
                                         input int lat_min, input int lat_max);
      mode_t m;
      m.full_page  = 1'b0;
      m.len_m1     = 3'd0;
      unique case (w[2:0])
         3'b001:  m.len_m1 = 3'd1;
         3'b010:  m.len_m1 = 3'd3;
         3'b011:  m.len_m1 = 3'd7;
         3'b111:  begin m.full_page = 1'b1; m.len_m1 = 3'd7; end
         default: m.len_m1 = 3'd0;
      endcase
      m.interleave = w[3];
      if (int'(w[8:4]) >= lat_min && int'(w[8:4]) <= lat_max)
         m.lat = w[6:4];
      else
         m.lat = 3'(lat_min);
      m.wr_single  = w[9];
      return m;
   endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
   import bcs_pkg::*;
#(
   parameter int LAT_MIN = 2,
   parameter int LAT_MAX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MODE_W-1:0] word,
   output mode_t             mode
);
   generate
      if (LAT_MIN < 2 || LAT_MAX > 7 || LAT_MAX < LAT_MIN) begin : g_bad_lat
         $error("bcs_mode_reg: latency range must lie within 2..7");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode <= decode_mode('0, LAT_MIN, LAT_MAX);
      else if (load) mode <= decode_mode(word, LAT_MIN, LAT_MAX);
   end

   assert_lat_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(mode.lat) >= LAT_MIN && int'(mode.lat) <= LAT_MAX));
endmodule

// File: rtl/bcs_beat_gen.sv
module bcs_beat_gen
   import bcs_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mode_t            mode_i,
   input  logic             cmd_rd,
   input  logic             cmd_wr,
   input  logic [COL_W-1:0] start_col,
   input  logic             burst_stop,
   output logic [COL_W-1:0] col_addr,
   output logic             beat_valid,
   output logic             beat_is_wr,
   output logic [2:0]       beat_lat
);
   localparam int LOW_W = 3;

   generate
      if (COL_W < LOW_W + 1) begin : g_bad_width
         $error("bcs_beat_gen: COL_W must exceed the 8-beat block width");
      end
   endgenerate

   logic             active_q, wr_q, fp_q, ilv_q;
   logic [2:0]       len_m1_q, k_q, lat_q;
   logic [COL_W-1:0] start_q, page_q;
   logic             cmd_any, cmd_is_wr, force_one, last_beat;
   logic [LOW_W-1:0] low_start, low_seq, low_ilv, low_sel;

   assign cmd_any   = cmd_rd | cmd_wr;
   assign cmd_is_wr = cmd_wr & ~cmd_rd;
   assign force_one = cmd_is_wr & mode_i.wr_single;
   assign last_beat = ~fp_q & (k_q == len_m1_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         wr_q     <= 1'b0;
         fp_q     <= 1'b0;
         ilv_q    <= 1'b0;
         len_m1_q <= '0;
         k_q      <= '0;
         lat_q    <= '0;
         start_q  <= '0;
         page_q   <= '0;
      end else if (cmd_any) begin
         active_q <= 1'b1;
         wr_q     <= cmd_is_wr;
         fp_q     <= mode_i.full_page & ~force_one;
         ilv_q    <= mode_i.interleave & ~mode_i.full_page;
         len_m1_q <= force_one ? 3'd0 : mode_i.len_m1;
         k_q      <= '0;
         lat_q    <= mode_i.lat;
         start_q  <= start_col;
         page_q   <= start_col;
      end else if (active_q) begin
         if (burst_stop || last_beat) begin
            active_q <= 1'b0;
         end else begin
            k_q    <= k_q + 3'd1;
            page_q <= page_q + 1'b1;
         end
      end
   end

   assign low_start = start_q[LOW_W-1:0];
   assign low_seq   = ((low_start + k_q) & len_m1_q) | (low_start & ~len_m1_q);
   assign low_ilv   = low_start ^ k_q;
   assign low_sel   = ilv_q ? low_ilv : low_seq;

   assign col_addr   = fp_q ? page_q : {start_q[COL_W-1:LOW_W], low_sel};
   assign beat_valid = active_q;
   assign beat_is_wr = wr_q;
   assign beat_lat   = lat_q;

   assert_start_needs_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(beat_valid) |-> $past(cmd_rd || cmd_wr));

   assert_block_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !fp_q && !cmd_any && !burst_stop && !last_beat)
      |=> (col_addr[COL_W-1:LOW_W] == $past(col_addr[COL_W-1:LOW_W])));

   assert_page_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && fp_q && !cmd_any && !burst_stop)
      |=> (col_addr == COL_W'($past(col_addr) + 1'b1)));

   assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_stop && !cmd_any) |=> !beat_valid);

   assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !cmd_rd && mode_i.wr_single)
      |=> beat_valid ##1 (!beat_valid || $past(cmd_rd || cmd_wr)));
endmodule

// File: rtl/bcs_lat_pipe.sv
module bcs_lat_pipe #(
   parameter int LAT_MIN = 2,
   parameter int LAT_MAX = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  logic [2:0] lat,
   output logic       dv
);
   localparam int N_LAT = LAT_MAX - LAT_MIN + 1;

   logic [N_LAT-1:0] taps;

   generate
      for (genvar i = 0; i < N_LAT; i++) begin : g_chain
         localparam int L = LAT_MIN + i;
         logic [L-2:0] sh;
         logic         in_bit;
         assign in_bit = push && (int'(lat) == L);
         if (L == 2) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh <= '0;
               else        sh <= in_bit;
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh <= '0;
               else        sh <= {sh[L-3:0], in_bit};
            end
         end
         assign taps[i] = sh[L-2];
      end
   endgenerate

   assign dv = |taps;

   assert_tap_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(taps));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bcs_pkg::*;
#(
   parameter int COL_W   = 9,
   parameter int LAT_MIN = 2,
   parameter int LAT_MAX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_load,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              cmd_rd,
   input  logic              cmd_wr,
   input  logic [COL_W-1:0]  start_col,
   input  logic              burst_stop,
   output logic [COL_W-1:0]  col_addr,
   output logic              col_valid,
   output logic              col_is_write,
   output logic              data_valid
);
   mode_t      mode;
   logic       beat_valid, beat_is_wr, rd_dv;
   logic [2:0] beat_lat;

   bcs_mode_reg #(.LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)) u_mode (
      .clk(clk), .rst_n(rst_n), .load(mode_load), .word(mode_word), .mode(mode));

   bcs_beat_gen #(.COL_W(COL_W)) u_beat (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
      .start_col(start_col), .burst_stop(burst_stop), .col_addr(col_addr),
      .beat_valid(beat_valid), .beat_is_wr(beat_is_wr), .beat_lat(beat_lat));

   bcs_lat_pipe #(.LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)) u_lat (
      .clk(clk), .rst_n(rst_n), .push(beat_valid & ~beat_is_wr), .lat(beat_lat),
      .dv(rd_dv));

   assign col_valid    = beat_valid;
   assign col_is_write = beat_is_wr;
   assign data_valid   = (beat_valid & beat_is_wr) | rd_dv;

   assert_read_no_early_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(col_valid) && !col_is_write && !$past(col_valid) |-> !data_valid);
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
   localparam int CLK_PERIOD = 10;
   localparam int COL_W      = 9;
   localparam int PAGE       = 1 << COL_W;
   localparam int WATCHDOG   = 20000;

   logic             clk = 1'b0, rst_n = 1'b0;
   logic             mode_load = 1'b0, cmd_rd = 1'b0, cmd_wr = 1'b0, burst_stop = 1'b0;
   logic [9:0]       mode_word = '0;
   logic [COL_W-1:0] start_col = '0;
   logic [COL_W-1:0] col_addr;
   logic             col_valid, col_is_write, data_valid;

   burst_col_seq #(.COL_W(COL_W)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
      .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .start_col(start_col), .burst_stop(burst_stop),
      .col_addr(col_addr), .col_valid(col_valid), .col_is_write(col_is_write),
      .data_valid(data_valid));

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_chk = 0, n_fail = 0, cyc = 0;
   string cur_req = "R1";
   bit    done = 0;

   // reference model state
   int m_len = 1, m_ilv = 0, m_lat = 2, m_ws = 0;
   int b_act = 0, b_wr = 0, b_len = 1, b_ilv = 0, b_lat = 2, b_start = 0, b_k = 0;
   int due[$];
   int exp_col = 0;
   bit exp_dv = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_len = 1; m_ilv = 0; m_lat = 2; m_ws = 0;
         b_act = 0; b_wr = 0; due.delete(); exp_dv = 0;
      end else begin
         if (cmd_rd || cmd_wr) begin
            b_act = 1; b_k = 0; b_start = int'(start_col);
            b_wr = (cmd_wr && !cmd_rd) ? 1 : 0;
            b_len = (b_wr && m_ws) ? 1 : m_len;
            b_ilv = m_ilv; b_lat = m_lat;
         end else if (b_act) begin
            if (burst_stop || (b_len != 0 && b_k == b_len - 1)) b_act = 0;
            else b_k++;
         end
         if (mode_load) begin
            case (int'(mode_word[2:0]))
               1: m_len = 2;  2: m_len = 4;  3: m_len = 8;  7: m_len = 0;
               default: m_len = 1;
            endcase
            m_ilv = int'(mode_word[3]);
            m_lat = (int'(mode_word[8:4]) == 3) ? 3 : 2;
            m_ws  = int'(mode_word[9]);
         end
         if (b_act && !b_wr) due.push_back(cyc + b_lat - 1);
         exp_dv = b_act && b_wr;
         for (int i = due.size() - 1; i >= 0; i--)
            if (due[i] == cyc) begin exp_dv = 1; due.delete(i); end
         if (b_len == 0) exp_col = (b_start + b_k) % PAGE;
         else begin
            int s, off;
            s   = b_start % b_len;
            off = b_ilv ? (s ^ b_k) : ((s + b_k) % b_len);
            exp_col = b_start - s + off;
         end
      end
   end

   task automatic check(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", cur_req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("col_valid", int'(col_valid), b_act);
         if (b_act) begin
            check("col_addr", int'(col_addr), exp_col);
            check("col_is_write", int'(col_is_write), b_wr);
         end
         check("data_valid", int'(data_valid), int'(exp_dv));
      end
   end

   always @(posedge clk) begin
      if (cyc > WATCHDOG && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_mode(input int lc, input int typ, input int lat, input int ws);
      @(negedge clk);
      mode_word = {1'(ws), 5'(lat), 1'(typ), 3'(lc)};
      mode_load = 1'b1;
      @(negedge clk);
      mode_load = 1'b0;
   endtask

   task automatic issue(input bit rd, input bit wr, input int col);
      @(negedge clk);
      cmd_rd = rd; cmd_wr = wr; start_col = COL_W'(col);
      @(negedge clk);
      cmd_rd = 1'b0; cmd_wr = 1'b0;
   endtask

   task automatic stop_now();
      @(negedge clk);
      burst_stop = 1'b1;
      @(negedge clk);
      burst_stop = 1'b0;
   endtask

   initial begin
      int starts[4] = '{0, 5, 2, 503};
      // R1: outputs quiet during and right after reset
      idle(3);
      cur_req = "R1";
      check("col_valid in reset", int'(col_valid), 0);
      check("data_valid in reset", int'(data_valid), 0);
      rst_n = 1'b1;
      idle(2);
      check("col_valid after reset", int'(col_valid), 0);
      check("data_valid after reset", int'(data_valid), 0);
      issue(1, 0, 77);        // R1 default mode: single read, latency 2
      idle(6);

      // R3 R4 R5 R9: fixed lengths, both orders, both latencies
      for (int lat = 2; lat <= 3; lat++)
         for (int lc = 1; lc <= 3; lc++)
            for (int typ = 0; typ <= 1; typ++) begin
               set_mode(lc, typ, lat, 0);
               foreach (starts[j]) begin
                  cur_req = typ ? "R5" : "R4";
                  if (lat == 3) cur_req = "R9";
                  issue(1, 0, starts[j]);
                  idle(12);
               end
            end

      // R2: reserved length codes, out-of-range latency, load with command
      cur_req = "R2";
      for (int lc = 4; lc <= 6; lc++) begin
         set_mode(lc, 0, 3, 0);
         issue(1, 0, 13);
         idle(6);
      end
      set_mode(3, 0, 9, 0);
      issue(1, 0, 21);
      idle(14);
      @(negedge clk);
      mode_word = {1'b0, 5'd3, 1'b0, 3'b001}; mode_load = 1'b1;
      cmd_rd = 1'b1; start_col = COL_W'(6);
      @(negedge clk);
      mode_load = 1'b0; cmd_rd = 1'b0;
      idle(14);

      // R6 R7: full page with the interleave bit set, wrapping the page top
      cur_req = "R6";
      set_mode(7, 1, 2, 0);
      issue(1, 0, 505);
      idle(14);
      cur_req = "R7";
      stop_now();
      idle(6);
      set_mode(3, 0, 2, 0);
      issue(0, 1, 40);
      idle(2);
      stop_now();
      idle(6);

      // R8: new commands cut off a running burst
      cur_req = "R8";
      issue(1, 0, 3);
      idle(2);
      issue(0, 1, 20);
      idle(1);
      issue(1, 0, 60);
      idle(14);

      // R10: write strobe aligned with the address beats
      cur_req = "R10";
      set_mode(2, 1, 3, 0);
      issue(0, 1, 9);
      idle(8);

      // R11: single-beat writes, reads keep their length
      cur_req = "R11";
      set_mode(3, 0, 2, 1);
      issue(0, 1, 30);
      idle(4);
      issue(1, 0, 30);
      idle(12);
      set_mode(7, 0, 2, 1);
      issue(0, 1, 100);
      idle(4);

      // R12: both command inputs at once
      cur_req = "R12";
      set_mode(2, 0, 2, 0);
      issue(1, 1, 14);
      idle(10);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule